// File: doc/BRIEF.md
# Keyed Single-Use Access Guard for IO Voltage-Domain Registers

This block guards a bank of per-domain IO supply-select words on a plain register bus. Each word holds one meaningful bit, which asks the pads of its domain to run at 1.8 V instead of the 3.3 V default. The bank cannot be reached casually. Software first writes a first key value to one key register and then a second key value to a second key register. That pair of writes arms the guard for exactly one access to the bank, read or write. The access uses up the unlock, and the bank locks again at once.

The bus has no handshake and no back-pressure. An access is offered in the cycle that `wr_en` or `rd_en` is high, and it is always taken in that cycle. Its response, `rdata` and `err`, is registered and appears in the next cycle. No data stream passes through the block, so none of its pins uses valid/ready. Every domain word also drives its own 1.8 V enable output directly.

Top module: `vdom_guard`

## Requirements
- R1: After reset every domain word and every `vdd18_en` bit is 0, and the guard is locked.
- R2: A write of exactly 0x0000BABA (the whole 32-bit word) to byte address 0x050 latches the first key. A write of exactly 0x0000EB10 to 0x054, made while the first key is latched, arms the guard. A key write with any other value, including one with non-zero upper bits, does not advance the sequence.
- R3: Order matters. A second-key write with no first key latched does not arm the guard, and a second-key write followed by a first-key write leaves the guard unarmed.
- R4: A wrong value written to either key register clears any key progress, so a later correct second-key write does not arm the guard.
- R5: After the first key is latched, any other access (a read or write at another address, or a read of a key register) discards it.
- R6: While the guard is armed, one write to the bank stores wdata bit 2 into the addressed word and disarms the guard. The matching `vdd18_en` bit shows the new value in the cycle after the write. A following bank access is locked.
- R7: While the guard is armed, one read of the bank returns the addressed word on `rdata` in the next cycle and disarms the guard.
- R8: A bank access made while the guard is locked changes no word. A locked read returns 0. Either kind raises `err` for exactly the one response cycle.
- R9: Domain i lives at byte address 0x800 + 4*i for i = 0 to 11, and it drives `vdd18_en[i]`. Address bits [1:0] are ignored. On a bank read, `rdata` carries the word's bit in position 2, and all other bits are 0.
- R10: While the guard is armed, an access outside the key registers and outside 0x800 to 0x82F leaves it armed and returns `rdata` 0 with `err` 0.
- R11: When `wr_en` and `rd_en` are both high, the access acts as a write, and `rdata` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte address of the access |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after the read |
| err | output | 1 | Locked-bank access flag, one cycle after the access |
| vdd18_en | output | 12 | Per-domain 1.8 V enable |

## Verification
The key sequence is tried in several forms: in the correct order, in reverse order, with the second key alone, with a wrong value in either key, with non-zero upper key bits, and with a stray read or write (a key-register read among them) between the two keys. Each of these is followed by a bank write. A correctly formed sequence is the only one whose bank write lands without an error, so this separates a guard that checks order, values and adjacency from one that only counts key writes. After a successful unlock, the bench tries a bank read and a bank write that both set the write and read strobes. These show that reads also use up the unlock and that the combined access acts as a write. A second access right after the first, and an access to an unrelated address made while armed, separate true single-use behaviour from a lock that never closes or one that closes too early. The first and last domain addresses, plus the addresses just outside the bank, exercise the address decode.

// File: rtl/vdom_pkg.sv
package vdom_pkg;
  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_HALF  = 2'd1,
    GS_ARMED = 2'd2
  } guard_state_t;

  localparam int EN_BIT = 2;
endpackage

// File: rtl/vdom_key_fsm.sv
module vdom_key_fsm
  import vdom_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY_A = 32'h0000_BABA,
  parameter logic [DATA_W-1:0] KEY_B = 32'h0000_EB10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_a_wr,
  input  logic              key_b_wr,
  input  logic              bank_acc,
  input  logic              other_acc,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed
);
  guard_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_a_wr)
      state_d = (wdata == KEY_A) ? GS_HALF : GS_IDLE;
    else if (key_b_wr)
      state_d = (state_q == GS_HALF && wdata == KEY_B) ? GS_ARMED : GS_IDLE;
    else if (bank_acc)
      state_d = GS_IDLE;
    else if (other_acc && state_q == GS_HALF)
      state_d = GS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= GS_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == GS_ARMED);

  // R6
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bank_acc) |=> !armed);

  // R3
  key_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_b_wr && state_q != GS_HALF) |=> !armed);

  // R5
  stray_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_HALF && other_acc) |=> state_q == GS_IDLE);
endmodule

// File: rtl/vdom_domain_bank.sv
module vdom_domain_bank #(
  parameter int N_DOM = 12,
  localparam int IDX_W = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [IDX_W-1:0] idx,
  input  logic             wbit,
  output logic [N_DOM-1:0] en
);
  for (genvar i = 0; i < N_DOM; i++) begin : g_dom
    always_ff @(posedge clk) begin
      if (!rst_n)
        en[i] <= 1'b0;
      else if (wr_stb && idx == IDX_W'(i))
        en[i] <= wbit;
    end
  end
endmodule

// File: rtl/vdom_guard.sv
module vdom_guard
  import vdom_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int N_DOM  = 12,
  parameter logic [ADDR_W-1:0] KEY_A_ADDR = 12'h050,
  parameter logic [ADDR_W-1:0] KEY_B_ADDR = 12'h054,
  parameter logic [ADDR_W-1:0] BANK_BASE  = 12'h800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic [N_DOM-1:0]  vdd18_en
);
  localparam int IDX_W = (N_DOM > 1) ? $clog2(N_DOM) : 1;
  localparam logic [ADDR_W:0] BANK_END = {1'b0, BANK_BASE} + (ADDR_W+1)'(4 * N_DOM);

  logic              acc, bank_hit, bank_acc, key_a_wr, key_b_wr, other_acc;
  logic              armed, grant, rd_only;
  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  idx;

  assign acc      = wr_en | rd_en;
  assign rd_only  = rd_en & ~wr_en;
  assign bank_hit = (addr >= BANK_BASE) && ({1'b0, addr} < BANK_END);
  assign off      = addr - BANK_BASE;
  assign idx      = off[IDX_W+1:2];
  assign bank_acc = acc && bank_hit;
  assign key_a_wr = wr_en && addr == KEY_A_ADDR;
  assign key_b_wr = wr_en && addr == KEY_B_ADDR;
  assign other_acc = acc && !bank_hit && !key_a_wr && !key_b_wr;
  assign grant    = bank_acc && armed;

  vdom_key_fsm #(.DATA_W(DATA_W)) u_keys (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_a_wr (key_a_wr),
    .key_b_wr (key_b_wr),
    .bank_acc (bank_acc),
    .other_acc(other_acc),
    .wdata    (wdata),
    .armed    (armed)
  );

  vdom_domain_bank #(.N_DOM(N_DOM)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_stb(grant && wr_en),
    .idx   (idx),
    .wbit  (wdata[EN_BIT]),
    .en    (vdd18_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      rdata <= '0;
      if (grant && rd_only)
        rdata[EN_BIT] <= vdd18_en[idx];
      err <= bank_acc && !armed;
    end
  end

  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~(DATA_W'(1) << EN_BIT)) == '0);

  // R8
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_acc && !armed) |=> $stable(vdd18_en));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(bank_acc));

  // R10
  stay_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && other_acc) |=> armed);
endmodule

// File: tb/test_vdom_guard.sv
module test_vdom_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [11:0] vdd18_en;

  int n_chk = 0, n_fail = 0;
  logic [11:0] exp_en = '0;
  logic        done = 1'b0;
  logic        e;
  logic [31:0] r;

  always #2 clk = ~clk;

  vdom_guard i_vdom_guard (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .err(err), .vdd18_en(vdd18_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic access(input logic w, input logic rd, input logic [11:0] a,
                        input logic [31:0] d, output logic oe, output logic [31:0] od);
    @(negedge clk);
    addr = a; wr_en = w; rd_en = rd; wdata = d;
    @(negedge clk);
    oe = err; od = rdata;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic unlock();
    access(1, 0, 12'h050, 32'h0000_BABA, e, r);
    access(1, 0, 12'h054, 32'h0000_EB10, e, r);
  endtask

  task automatic t_reset();
    chk("R1 enables", 32'(vdd18_en), 0);
    chk("R1 err", 32'(err), 0);
    access(1, 0, 12'h808, 32'h4, e, r);
    chk("R1 locked err", 32'(e), 1);
    chk("R8 locked write ignored", 32'(vdd18_en), 0);
    @(negedge clk);
    chk("R8 err one cycle", 32'(err), 0);
    access(0, 1, 12'h808, 32'h0, e, r);
    chk("R8 locked read zero", r, 0);
    chk("R8 locked read err", 32'(e), 1);
  endtask

  task automatic t_write_once();
    unlock();
    access(1, 0, 12'h808, 32'hFFFF_FFFF, e, r);
    exp_en[2] = 1'b1;
    chk("R6 armed write no err", 32'(e), 0);
    chk("R6 enable updated", 32'(vdd18_en), 32'(exp_en));
    access(1, 0, 12'h808, 32'h0, e, r);
    chk("R6 relocked err", 32'(e), 1);
    chk("R6 relocked unchanged", 32'(vdd18_en), 32'(exp_en));
  endtask

  task automatic t_read_once();
    unlock();
    access(0, 1, 12'h80A, 32'h0, e, r);
    chk("R7 read value", r, 32'h4);
    chk("R7 read no err", 32'(e), 0);
    access(0, 1, 12'h808, 32'h0, e, r);
    chk("R7 read consumed err", 32'(e), 1);
    chk("R9 locked read zero", r, 0);
  endtask

  task automatic t_order();
    access(1, 0, 12'h054, 32'h0000_EB10, e, r);
    access(1, 0, 12'h80C, 32'h4, e, r);
    chk("R3 second key alone", 32'(e), 1);
    access(1, 0, 12'h054, 32'h0000_EB10, e, r);
    access(1, 0, 12'h050, 32'h0000_BABA, e, r);
    access(1, 0, 12'h80C, 32'h4, e, r);
    chk("R3 reversed keys", 32'(e), 1);
    chk("R3 unchanged", 32'(vdd18_en), 32'(exp_en));
  endtask

  task automatic t_wrong();
    access(1, 0, 12'h050, 32'h0000_BABA, e, r);
    access(1, 0, 12'h050, 32'h0000_BABB, e, r);
    access(1, 0, 12'h054, 32'h0000_EB10, e, r);
    access(1, 0, 12'h810, 32'h4, e, r);
    chk("R4 wrong first key", 32'(e), 1);
    access(1, 0, 12'h050, 32'h0000_BABA, e, r);
    access(1, 0, 12'h054, 32'h0000_EB11, e, r);
    access(1, 0, 12'h054, 32'h0000_EB10, e, r);
    access(1, 0, 12'h810, 32'h4, e, r);
    chk("R4 wrong second key", 32'(e), 1);
    access(1, 0, 12'h050, 32'h0001_BABA, e, r);
    access(1, 0, 12'h054, 32'h0000_EB10, e, r);
    access(1, 0, 12'h810, 32'h4, e, r);
    chk("R2 upper key bits", 32'(e), 1);
    chk("R4 unchanged", 32'(vdd18_en), 32'(exp_en));
  endtask

  task automatic t_stray();
    access(1, 0, 12'h050, 32'h0000_BABA, e, r);
    access(0, 1, 12'h100, 32'h0, e, r);
    access(1, 0, 12'h054, 32'h0000_EB10, e, r);
    access(1, 0, 12'h814, 32'h4, e, r);
    chk("R5 stray read", 32'(e), 1);
    access(1, 0, 12'h050, 32'h0000_BABA, e, r);
    access(1, 0, 12'h100, 32'h1234, e, r);
    access(1, 0, 12'h054, 32'h0000_EB10, e, r);
    access(1, 0, 12'h814, 32'h4, e, r);
    chk("R5 stray write", 32'(e), 1);
    access(1, 0, 12'h050, 32'h0000_BABA, e, r);
    access(0, 1, 12'h050, 32'h0, e, r);
    access(1, 0, 12'h054, 32'h0000_EB10, e, r);
    access(1, 0, 12'h814, 32'h4, e, r);
    chk("R5 key read", 32'(e), 1);
    chk("R5 unchanged", 32'(vdd18_en), 32'(exp_en));
  endtask

  task automatic t_armed_other();
    unlock();
    access(0, 1, 12'h100, 32'h0, e, r);
    chk("R10 other read data", r, 0);
    chk("R10 other read err", 32'(e), 0);
    access(1, 0, 12'h830, 32'h4, e, r);
    chk("R10 past bank end err", 32'(e), 0);
    access(0, 1, 12'h7FC, 32'h0, e, r);
    chk("R10 below bank err", 32'(e), 0);
    access(1, 0, 12'h82C, 32'h4, e, r);
    exp_en[11] = 1'b1;
    chk("R10 still armed", 32'(e), 0);
    chk("R9 last domain", 32'(vdd18_en), 32'(exp_en));
  endtask

  task automatic t_both();
    unlock();
    access(1, 1, 12'h800, 32'h4, e, r);
    exp_en[0] = 1'b1;
    chk("R11 acts as write", 32'(vdd18_en), 32'(exp_en));
    chk("R11 rdata zero", r, 0);
    chk("R11 no err", 32'(e), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_once();
    t_read_once();
    t_order();
    t_wrong();
    t_stray();
    t_armed_other();
    t_both();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule